// File: doc/BRIEF.md
# Translation Cache with Domain Access Check

This block translates 32-bit virtual addresses into physical addresses through a fully associative cache of translations. Each cached translation covers either a 1 MB section or a 4 KB page. A lookup that hits passes through two access checks. The first is a per-domain check: there are 16 domains, and each has a 2-bit rights code held in a domain rights vector. The second is a per-entry permission check. The result is either a physical address or an abort.

A lookup that misses raises a walk request towards an external table walker. It then waits until a refill entry arrives. The refill is written into the cache in round-robin order, and the stalled access completes using that entry. A flush input clears every cached translation in one cycle. When translation is disabled, the virtual address is returned unchanged and no access check is made.

Top module: `tlb_domain_top`

## Requirements
- R1: After reset, no translation is cached, `rsp_valid` and `walk_req` are low, and the first translated access misses.
- R2: With `mmu_en` low, an accepted request returns `rsp_pa` equal to `req_va` one cycle later, with `rsp_abort` low and no walk, whatever the domain rights and mode.
- R3: A section entry (`refill_sect`=1) matches when VA[31:20] equals the stored tag, and it yields PA = {`refill_ptag`[19:8], VA[19:0]}.
- R4: A page entry (`refill_sect`=0) matches only when VA[31:12] equals the stored tag, and it yields PA = {`refill_ptag`, VA[11:0]}.
- R5: A hit produces `rsp_valid` exactly one cycle after the request is accepted.
- R6: On a miss, `walk_req` and `req_stall` rise one cycle after the request, and `walk_va` holds the request address. Both stay high until `refill_valid` is seen. One cycle after the refill, the response is produced from the refilled entry.
- R7: The rights code of domain d is `dacr`[2d+1:2d]. Code 00 aborts, 01 applies the entry permission, 10 aborts, and 11 permits with no permission check. An aborted response drives `rsp_pa` to zero.
- R8: The entry permission `ap` works as follows. 00 always aborts. 01 aborts any user access. 10 aborts a user write only. 11 never aborts.
- R9: Refills take slots in round-robin order, so the 65th distinct refill evicts the translation that was written first.
- R10: `flush` invalidates every cached translation at once, and the following accesses miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mmu_en | input | 1 | Translation enable |
| flush | input | 1 | Invalidate all entries |
| dacr | input | 32 | Domain rights, 2 bits per domain |
| req_valid | input | 1 | Access request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is in user mode |
| req_stall | output | 1 | Request not accepted (walk pending) |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_abort | output | 1 | Access refused |
| walk_req | output | 1 | Table walk requested |
| walk_va | output | 32 | Address to walk |
| refill_valid | input | 1 | Refill entry present |
| refill_sect | input | 1 | Refill is a section |
| refill_ptag | input | 20 | Physical base PA[31:12] |
| refill_dom | input | 4 | Refill domain |
| refill_ap | input | 2 | Refill entry permission |

## Verification
Several properties are checked by assertions on every cycle: bypass returns the address unchanged with no abort, a pending walk holds its address until a refill comes, a refill completes the stalled access on the next cycle, aborts always carry a zero address, and a flush empties the array. Other behaviour can only be shown by the bench's scenarios. This covers address composition for sections and pages, the full sweep of domain codes against entry permissions, mode and direction, the round-robin eviction order across a full array, and misses after a flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W  = 32;
    localparam int TAG_W = 20;
    localparam int DOM_N = 16;
    localparam int DOM_W = $clog2(DOM_N);

    typedef enum logic [1:0] {
        DOM_NONE   = 2'b00,
        DOM_CLIENT = 2'b01,
        DOM_RSVD   = 2'b10,
        DOM_MGR    = 2'b11
    } dom_code_e;

    typedef enum logic [1:0] {
        AP_NONE   = 2'b00,
        AP_SVC    = 2'b01,
        AP_USR_RO = 2'b10,
        AP_FULL   = 2'b11
    } ap_code_e;

    typedef struct packed {
        logic             valid;
        logic             sect;
        logic [TAG_W-1:0] vtag;
        logic [TAG_W-1:0] ptag;
        logic [DOM_W-1:0] dom;
        logic [1:0]       ap;
    } tlb_ent_t;

    typedef struct packed {
        logic            busy;
        logic [VA_W-1:0] va;
        logic            wr;
        logic            usr;
        logic            rsp_v;
        logic [VA_W-1:0] pa;
        logic            ab;
    } tlb_state_t;

    function automatic logic [VA_W-1:0] form_pa(input tlb_ent_t e, input logic [VA_W-1:0] va);
        if (e.sect) return {e.ptag[TAG_W-1:8], va[19:0]};
        return {e.ptag, va[11:0]};
    endfunction

endpackage

// File: rtl/tlb_rr_victim.sv
module tlb_rr_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
            else                              ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign idx = ptr_q;

    AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx));                                   // R9
    AST_RR_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> idx != $past(idx));                                // R9

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_hit,
    output tlb_ent_t         lk_ent
);

    tlb_ent_t             ent_d [ENTRIES];
    tlb_ent_t             ent_q [ENTRIES];
    logic [ENTRIES-1:0]   match;
    logic                 any_valid;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic sect_eq, page_eq;
        assign sect_eq  = ent_q[g].vtag[TAG_W-1:8] == lk_va[31:20];
        assign page_eq  = ent_q[g].vtag == lk_va[31:12];
        assign match[g] = ent_q[g].valid && (ent_q[g].sect ? sect_eq : page_eq);
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_ent = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_ent = ent_q[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) ent_d[i] = ent_q[i];
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) ent_d[i].valid = 1'b0;
        end else if (wr_en) begin
            ent_d[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int i = 0; i < ENTRIES; i++) any_valid = any_valid | ent_q[i].valid;
    end

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !any_valid);                                     // R10
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> any_valid);                          // R6

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlb_pkg::*;
(
    input  logic [2*DOM_N-1:0] dacr,
    input  logic [DOM_W-1:0]   dom,
    input  logic [1:0]         ap,
    input  logic               user,
    input  logic               write,
    output logic               deny
);

    dom_code_e code;
    logic      ap_deny;

    always_comb begin
        code = dom_code_e'(dacr[2*int'(dom) +: 2]);
        unique case (ap_code_e'(ap))
            AP_NONE:   ap_deny = 1'b1;
            AP_SVC:    ap_deny = user;
            AP_USR_RO: ap_deny = user & write;
            AP_FULL:   ap_deny = 1'b0;
            default:   ap_deny = 1'b1;
        endcase
        unique case (code)
            DOM_CLIENT: deny = ap_deny;
            DOM_MGR:    deny = 1'b0;
            DOM_NONE,
            DOM_RSVD:   deny = 1'b1;
            default:    deny = 1'b1;
        endcase
    end

endmodule

// File: rtl/tlb_domain_top.sv
module tlb_domain_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mmu_en,
    input  logic        flush,
    input  logic [31:0] dacr,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    input  logic        req_write,
    input  logic        req_user,
    output logic        req_stall,
    output logic        rsp_valid,
    output logic [31:0] rsp_pa,
    output logic        rsp_abort,
    output logic        walk_req,
    output logic [31:0] walk_va,
    input  logic        refill_valid,
    input  logic        refill_sect,
    input  logic [19:0] refill_ptag,
    input  logic [3:0]  refill_dom,
    input  logic [1:0]  refill_ap
);

    tlb_state_t       s_d, s_q;
    logic             lk_hit;
    tlb_ent_t         lk_ent;
    tlb_ent_t         new_ent;
    tlb_ent_t         chk_ent;
    logic             chk_user, chk_write, deny;
    logic             wr_en, adv;
    logic [IDX_W-1:0] victim;

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  (wr_en),
        .wr_idx (victim),
        .wr_ent (new_ent),
        .lk_va  (req_va),
        .lk_hit (lk_hit),
        .lk_ent (lk_ent)
    );

    tlb_rr_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .idx   (victim)
    );

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.sect  = refill_sect;
        new_ent.vtag  = s_q.va[31:12];
        new_ent.ptag  = refill_ptag;
        new_ent.dom   = refill_dom;
        new_ent.ap    = refill_ap;
    end

    always_comb begin
        if (s_q.busy) begin
            chk_ent   = new_ent;
            chk_user  = s_q.usr;
            chk_write = s_q.wr;
        end else begin
            chk_ent   = lk_ent;
            chk_user  = req_user;
            chk_write = req_write;
        end
    end

    tlb_perm_check u_perm (
        .dacr  (dacr),
        .dom   (chk_ent.dom),
        .ap    (chk_ent.ap),
        .user  (chk_user),
        .write (chk_write),
        .deny  (deny)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        s_d.pa    = '0;
        s_d.ab    = 1'b0;
        wr_en     = 1'b0;
        adv       = 1'b0;
        if (!s_q.busy) begin
            if (req_valid) begin
                if (!mmu_en) begin
                    s_d.rsp_v = 1'b1;
                    s_d.pa    = req_va;
                end else if (lk_hit) begin
                    s_d.rsp_v = 1'b1;
                    s_d.ab    = deny;
                    s_d.pa    = deny ? '0 : form_pa(lk_ent, req_va);
                end else begin
                    s_d.busy = 1'b1;
                    s_d.va   = req_va;
                    s_d.wr   = req_write;
                    s_d.usr  = req_user;
                end
            end
        end else if (refill_valid) begin
            wr_en     = 1'b1;
            adv       = 1'b1;
            s_d.busy  = 1'b0;
            s_d.rsp_v = 1'b1;
            s_d.ab    = deny;
            s_d.pa    = deny ? '0 : form_pa(new_ent, s_q.va);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_stall = s_q.busy;
    assign walk_req  = s_q.busy;
    assign walk_va   = s_q.va;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_pa    = s_q.pa;
    assign rsp_abort = s_q.ab;

    AST_BYPASS_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_stall && !mmu_en) |=>
            (rsp_valid && !rsp_abort && rsp_pa == $past(req_va)));   // R2
    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !refill_valid) |=> (walk_req && $stable(walk_va))); // R6
    AST_REFILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && refill_valid) |=> (rsp_valid && !walk_req));   // R6
    AST_NO_RSP_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !rsp_valid);                                    // R5
    AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> (rsp_valid && rsp_pa == '0));                  // R7
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !walk_req) |=> !rsp_valid);                   // R5

endmodule

// File: tb/tlb_domain_top_test.sv
module tlb_domain_top_test;
    localparam int CLK_NS = 10;
    localparam int N      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmu_en = 1'b0, flush = 1'b0;
    logic [31:0] dacr = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_stall, rsp_valid, rsp_abort, walk_req;
    logic [31:0] rsp_pa, walk_va;
    logic        refill_valid = 1'b0, refill_sect = 1'b0;
    logic [19:0] refill_ptag = '0;
    logic [3:0]  refill_dom = '0;
    logic [1:0]  refill_ap = '0;

    int total = 0, bad = 0;

    tlb_domain_top #(.ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .flush(flush), .dacr(dacr),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
        .req_stall(req_stall), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort),
        .walk_req(walk_req), .walk_va(walk_va), .refill_valid(refill_valid),
        .refill_sect(refill_sect), .refill_ptag(refill_ptag), .refill_dom(refill_dom),
        .refill_ap(refill_ap)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", rq, what, got, exp);
        end
    endtask

    function automatic bit exp_deny(input logic [1:0] code, input logic [1:0] ap,
                                    input logic usr, input logic wr);
        if (code == 2'b11) return 1'b0;
        if (code != 2'b01) return 1'b1;
        case (ap)
            2'b00:   return 1'b1;
            2'b01:   return usr;
            2'b10:   return usr & wr;
            default: return 1'b0;
        endcase
    endfunction

    task automatic access(input logic [31:0] va, input logic wr, input logic usr,
                          input bit exp_miss, input logic rsect, input logic [19:0] rptag,
                          input logic [3:0] rdom, input logic [1:0] rap,
                          input logic [31:0] exp_pa, input bit exp_ab, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        check(walk_req == exp_miss, rq, "miss", 32'(walk_req), 32'(exp_miss));
        if (walk_req) begin
            check(walk_va == va && req_stall && !rsp_valid, "R6", "walk_va", walk_va, va);
            repeat (2) @(negedge clk);
            check(walk_req && walk_va == va, "R6", "walk held", walk_va, va);
            refill_valid = 1'b1; refill_sect = rsect; refill_ptag = rptag;
            refill_dom = rdom; refill_ap = rap;
            @(negedge clk);
            refill_valid = 1'b0;
        end
        check(rsp_valid, rq, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(rsp_pa == exp_pa, rq, "pa", rsp_pa, exp_pa);
        check(rsp_abort == exp_ab, rq, "abort", 32'(rsp_abort), 32'(exp_ab));
        @(negedge clk);
        check(!rsp_valid, "R5", "single strobe", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R6", "watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rsp_valid && !walk_req, "R1", "reset outputs", {rsp_valid, walk_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && !walk_req && !req_stall, "R1", "idle after reset",
              {rsp_valid, walk_req}, 32'd0);

        // R2: bypass with every domain set to no access
        dacr = 32'h0;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] va;
            va = 32'h1357_9BDF * 32'(i + 1);
            access(va, i[0], i[1], 1'b0, 1'b0, '0, '0, '0, va, 1'b0, "R2");
        end

        mmu_en = 1'b1;
        dacr   = 32'h5555_5555;
        // R1 + R4: first access misses; page refill
        access(32'h0001_2345, 1'b0, 1'b0, 1'b1, 1'b0, 20'h80040, 4'd1, 2'b11,
               32'h8004_0345, 1'b0, "R1");
        access(32'h0001_2FFF, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0, '0,
               32'h8004_0FFF, 1'b0, "R4");
        access(32'h0001_3000, 1'b0, 1'b0, 1'b1, 1'b0, 20'h80041, 4'd1, 2'b11,
               32'h8004_1000, 1'b0, "R4");
        // R3: section refill, then hit in another page of the same MB
        access(32'h0234_5678, 1'b0, 1'b0, 1'b1, 1'b1, 20'hABC00, 4'd3, 2'b11,
               32'hABC4_5678, 1'b0, "R3");
        access(32'h023F_FFF0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0,
               32'hABCF_FFF0, 1'b0, "R3");
        // R6: refilled entry itself refused (client, ap 00)
        access(32'h0300_0010, 1'b0, 1'b0, 1'b1, 1'b0, 20'h12345, 4'd5, 2'b00,
               32'h0, 1'b1, "R6");

        // R7 / R8: fill four pages of domain 2 with each ap, then sweep
        dacr = 32'hFFFF_FFFF;
        for (int a = 0; a < 4; a++)
            access(32'h4000_0000 + 32'(a << 12), 1'b0, 1'b0, 1'b1, 1'b0,
                   20'h50000 + 20'(a), 4'd2, 2'(a), 32'h5000_0000 + 32'(a << 12), 1'b0, "R8");
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 4; a++)
                for (int m = 0; m < 4; m++) begin
                    bit d;
                    dacr = (32'h5555_5555 & ~32'h30) | 32'(c << 4);
                    d = exp_deny(2'(c), 2'(a), m[1], m[0]);
                    access(32'h4000_0000 + 32'(a << 12) + 32'h44, m[0], m[1], 1'b0, 1'b0,
                           '0, '0, '0, d ? 32'h0 : 32'h5000_0044 + 32'(a << 12), d,
                           c[0] ? "R8" : "R7");
                end

        // R10: flush, then a cached page misses
        dacr = 32'h5555_5555;
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        access(32'h0001_2345, 1'b0, 1'b0, 1'b1, 1'b0, 20'h80040, 4'd1, 2'b11,
               32'h8004_0345, 1'b0, "R10");
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;

        // R9: fill all slots, all hit, then the 65th evicts the oldest
        for (int i = 0; i < N; i++)
            access(32'h6000_0000 + 32'(i << 12), 1'b0, 1'b0, 1'b1, 1'b0, 20'h70000 + 20'(i),
                   4'd0, 2'b11, 32'h7000_0000 + 32'(i << 12), 1'b0, "R9");
        for (int i = 0; i < N; i++)
            access(32'h6000_0000 + 32'(i << 12) + 32'h8, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0,
                   32'h7000_0008 + 32'(i << 12), 1'b0, "R9");
        access(32'h6000_0000 + 32'(N << 12), 1'b0, 1'b0, 1'b1, 1'b0, 20'h70000 + 20'(N),
               4'd0, 2'b11, 32'h7000_0000 + 32'(N << 12), 1'b0, "R9");
        access(32'h6000_1000, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, 32'h7000_1000, 1'b0, "R9");
        access(32'h6000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 20'h70000, 4'd0, 2'b11,
               32'h7000_0000, 1'b0, "R9");
        access(32'h6000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 20'h70001, 4'd0, 2'b11,
               32'h7000_1000, 1'b0, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule